// File: doc/BRIEF.md
# Double-Buffered Transmit Endpoint Packet Buffer

This block holds outgoing packets for one host-side transmit endpoint. Software fills a packet one byte at a time through a byte write port and then commits it by writing a ready command to the control register. The link side sees the oldest committed packet, reads its bytes in order, and signals a transmit-done pulse when it has sent the packet. That pulse frees the buffer. Up to two packets can be held when double buffering is configured, and one packet otherwise.

Software can discard packets with a drop command. A drop on its own removes the newest committed packet. A drop written in the same register write as the ready command instead aborts the packet that is still being filled. A drop issued while nothing is committed is treated as a misuse: it leaves everything as it was and sets a sticky error flag. Valid drops, aborts and completed transmissions raise a level interrupt. Software clears that interrupt through an event register.

Top module: `txep_dbuf_fifo`

## Requirements
- R1: After reset, both registers read 0, `irq` is low and `lnk_avail` is low.
- R2: Bytes written on the byte port fill the current loading buffer. Writing 1 to control bit 0 (address 0) commits that buffer, and its length is latched. The link side then sees `lnk_avail` high and `lnk_len` equal to the byte count, and it reads the bytes on `lnk_data` in write order, one per `lnk_rd` pulse.
- R3: Bytes beyond 64 in one buffer are ignored, so the length saturates at 64. Byte writes and commits are also ignored while no buffer is free.
- R4: With `cfg_dbl_en` low the block holds one packet. With it high the block holds two, and the link side receives them oldest first.
- R5: Writing 1 to control bit 1 alone, while a packet is committed, discards the newest committed packet together with any partly loaded bytes and sets the interrupt. Control bit 0 (reads "packet committed") falls by itself once no packet remains.
- R6: In double-buffer mode a drop removes exactly one packet, so two drops are needed to empty two committed packets.
- R7: Writing control bits 0 and 1 together aborts the partly loaded packet, discarding its bytes. Committed packets are not touched, and the interrupt is set.
- R8: A drop written while control bit 0 reads 0 changes no stored data or length. It sets event bit 1 and does not set the interrupt.
- R9: Control bit 2 (FIFO not empty) reads 1 only while control bit 0 reads 1. It reads 0 even if bytes are partly loaded.
- R10: A `lnk_done` pulse while a packet is committed frees the oldest packet and sets the interrupt.
- R11: `irq` (event bit 0, address 1) stays high until software writes 1 to event bit 0. Event bit 1 clears when software writes 1 to it. Control bit 1 always reads 0.
- R12: A change of `cfg_dbl_en` empties both buffers and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dbl_en | input | 1 | Static double-buffer enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 events |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data for `reg_addr` |
| byte_wr | input | 1 | Byte write strobe into the loading buffer |
| byte_data | input | DW | Byte to load |
| lnk_avail | output | 1 | A committed packet is available |
| lnk_len | output | CW | Length of the oldest committed packet |
| lnk_data | output | DW | Byte at the link read pointer |
| lnk_rd | input | 1 | Advance the link read pointer |
| lnk_done | input | 1 | Oldest packet transmitted; free it |
| irq | output | 1 | Level interrupt |

## Verification
Some properties can be checked on every cycle. These are the packet count bound, one packet removed per drop, a misused drop leaving the lengths frozen, and the masking of the not-empty bit. Others are the length ceiling, the interrupt holding until cleared, and the wipe on a mode change. Other behaviour shows only in the bench's scenarios. That covers which packet a drop or abort removes, oldest-first delivery, byte order on the link side, and the way ignored byte writes and commits fail to reach later packets.

// File: rtl/txep_pkg.sv
package txep_pkg;
   localparam int unsigned CTL_COMMIT = 0;
   localparam int unsigned CTL_DROP   = 1;
   localparam int unsigned CTL_NE     = 2;
   localparam int unsigned EV_IRQ     = 0;
   localparam int unsigned EV_BAD     = 1;

   typedef enum logic {
      RA_CTRL   = 1'b0,
      RA_EVENTS = 1'b1
   } reg_sel_e;

   typedef struct packed {
      logic commit;
      logic drop;
      logic clr_irq;
      logic clr_bad;
   } cmd_t;
endpackage

// File: rtl/txep_pkt_ram.sv
module txep_pkt_ram #(
   parameter int DW        = 8,
   parameter int PKT_BYTES = 64,
   parameter int NSLOT     = 2,
   localparam int PW       = $clog2(PKT_BYTES)
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic          wr_slot,
   input  logic [PW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_slot,
   input  logic [PW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);
   logic [DW-1:0] bank_out [NSLOT];

   for (genvar s = 0; s < NSLOT; s++) begin : g_bank
      logic [DW-1:0] store [PKT_BYTES];
      always_ff @(posedge clk) begin
         if (wr_en && (wr_slot == 1'(s))) store[wr_addr] <= wr_data;
      end
      assign bank_out[s] = store[rd_addr];
   end

   assign rd_data = bank_out[rd_slot];
endmodule

// File: rtl/txep_slot_ctrl.sv
module txep_slot_ctrl #(
   parameter int PKT_BYTES = 64,
   localparam int CW       = $clog2(PKT_BYTES + 1),
   localparam int PW       = $clog2(PKT_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_dbl_en,
   input  logic          cmd_commit,
   input  logic          cmd_drop,
   input  logic          byte_wr,
   input  logic          lnk_rd,
   input  logic          lnk_done,
   output logic          pkt_rdy,
   output logic          load_busy,
   output logic          ev_irq,
   output logic          ev_bad,
   output logic          wr_en,
   output logic          wr_slot,
   output logic [PW-1:0] wr_addr,
   output logic          rd_slot,
   output logic [PW-1:0] rd_addr,
   output logic          lnk_avail,
   output logic [CW-1:0] lnk_len
);
   localparam logic [CW-1:0] FULL_LEN = CW'(PKT_BYTES);

   logic               cfg_q;
   logic               rd_q;
   logic [1:0]         nc_q;
   logic [CW-1:0]      rptr_q;
   logic [1:0][CW-1:0] cnt_q;
   logic [1:0][CW-1:0] cnt_d;

   logic          cfg_chg, done_ok, rd1, ld0, ld1, newest, has_room;
   logic [1:0]    cap, n1, nc_d;
   logic          commit_ok, abort_ok, drop_ok, drop_bad, bw_ok;
   logic [CW-1:0] ld_base, rptr_d;

   // next-state arithmetic: link completion applies first, CPU command second
   always_comb begin
      cfg_chg  = (cfg_dbl_en != cfg_q);
      cap      = cfg_q ? 2'd2 : 2'd1;
      done_ok  = lnk_done && (nc_q != 2'd0);
      rd1      = (done_ok && cfg_q) ? ~rd_q : rd_q;
      n1       = nc_q - {1'b0, done_ok};
      has_room = (n1 < cap);
      ld0      = cfg_q ? (rd_q ^ nc_q[0]) : 1'b0;
      ld1      = cfg_q ? (rd1 ^ n1[0]) : 1'b0;
      newest   = cfg_q ? (rd1 ^ n1[1]) : 1'b0;
      ld_base  = (done_ok && (ld1 == rd_q)) ? '0 : cnt_q[ld1];

      abort_ok  = cmd_commit && cmd_drop && has_room;
      commit_ok = cmd_commit && !cmd_drop && has_room;
      drop_ok   = cmd_drop && !cmd_commit && (n1 != 2'd0);
      drop_bad  = cmd_drop && !cmd_commit && (n1 == 2'd0);
      bw_ok     = byte_wr && has_room && !cmd_drop && (ld_base < FULL_LEN);

      nc_d = n1 + {1'b0, commit_ok} - {1'b0, drop_ok};

      if (done_ok || (drop_ok && (n1 == 2'd1)))
         rptr_d = '0;
      else if (lnk_rd && (nc_q != 2'd0) && (rptr_q < cnt_q[rd_q]))
         rptr_d = rptr_q + CW'(1);
      else
         rptr_d = rptr_q;
   end

   for (genvar s = 0; s < 2; s++) begin : g_len
      always_comb begin
         cnt_d[s] = cnt_q[s];
         if (done_ok && (rd_q == 1'(s)))                        cnt_d[s] = '0;
         if (bw_ok && (ld1 == 1'(s)))                           cnt_d[s] = cnt_d[s] + CW'(1);
         if (abort_ok && (ld1 == 1'(s)))                        cnt_d[s] = '0;
         if (drop_ok && (newest == 1'(s)))                      cnt_d[s] = '0;
         if (drop_ok && has_room && (ld1 == 1'(s)))             cnt_d[s] = '0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       cnt_q[s] <= '0;
         else if (cfg_chg) cnt_q[s] <= '0;
         else              cnt_q[s] <= cnt_d[s];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= 1'b0;
         rd_q   <= 1'b0;
         nc_q   <= 2'd0;
         rptr_q <= '0;
      end else if (cfg_chg) begin
         cfg_q  <= cfg_dbl_en;
         rd_q   <= 1'b0;
         nc_q   <= 2'd0;
         rptr_q <= '0;
      end else begin
         rd_q   <= rd1;
         nc_q   <= nc_d;
         rptr_q <= rptr_d;
      end
   end

   assign pkt_rdy   = (nc_q != 2'd0);
   assign load_busy = (nc_q < cap) && (cnt_q[ld0] != '0);
   assign ev_irq    = !cfg_chg && (drop_ok || abort_ok || done_ok);
   assign ev_bad    = !cfg_chg && drop_bad;
   assign wr_en     = bw_ok && !cfg_chg;
   assign wr_slot   = ld1;
   assign wr_addr   = ld_base[PW-1:0];
   assign rd_slot   = rd_q;
   assign rd_addr   = rptr_q[PW-1:0];
   assign lnk_avail = pkt_rdy;
   assign lnk_len   = pkt_rdy ? cnt_q[rd_q] : '0;

   p_fill_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      nc_q <= (cfg_q ? 2'd2 : 2'd1));

   p_len_ceiling_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[0] <= FULL_LEN) && (cnt_q[1] <= FULL_LEN));

   p_commit_shows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_commit && !cmd_drop && !lnk_done && (nc_q == 2'd0) && (cfg_dbl_en == cfg_q))
      |=> lnk_avail);

   p_one_per_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_drop && !cmd_commit && !lnk_done && (nc_q != 2'd0) && (cfg_dbl_en == cfg_q))
      |=> (nc_q == $past(nc_q) - 2'd1));

   p_bad_drop_inert_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_drop && !cmd_commit && !lnk_done && (nc_q == 2'd0) && (cfg_dbl_en == cfg_q))
      |=> ((nc_q == 2'd0) && $stable(cnt_q)));

   p_mode_wipe_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_dbl_en != cfg_q) |=> ((nc_q == 2'd0) && (cnt_q == '0)));
endmodule

// File: rtl/txep_csr.sv
module txep_csr
   import txep_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic          reg_addr,
   input  logic [DW-1:0] reg_wdata,
   input  logic          pkt_rdy,
   input  logic          load_busy,
   input  logic          ev_irq,
   input  logic          ev_bad,
   output logic          cmd_commit,
   output logic          cmd_drop,
   output logic [DW-1:0] reg_rdata,
   output logic          irq
);
   cmd_t     cmd;
   reg_sel_e sel;
   logic     irq_q, bad_q, ne_raw;

   always_comb begin
      sel         = reg_sel_e'(reg_addr);
      cmd.commit  = reg_wr && (sel == RA_CTRL)   && reg_wdata[CTL_COMMIT];
      cmd.drop    = reg_wr && (sel == RA_CTRL)   && reg_wdata[CTL_DROP];
      cmd.clr_irq = reg_wr && (sel == RA_EVENTS) && reg_wdata[EV_IRQ];
      cmd.clr_bad = reg_wr && (sel == RA_EVENTS) && reg_wdata[EV_BAD];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         bad_q <= 1'b0;
      end else begin
         irq_q <= ev_irq || (irq_q && !cmd.clr_irq);
         bad_q <= ev_bad || (bad_q && !cmd.clr_bad);
      end
   end

   // not-empty is only meaningful with a committed packet present
   assign ne_raw = pkt_rdy || load_busy;

   always_comb begin
      reg_rdata = '0;
      if (sel == RA_CTRL) begin
         reg_rdata[CTL_COMMIT] = pkt_rdy;
         reg_rdata[CTL_NE]     = pkt_rdy && ne_raw;
      end else begin
         reg_rdata[EV_IRQ] = irq_q;
         reg_rdata[EV_BAD] = bad_q;
      end
   end

   assign cmd_commit = cmd.commit;
   assign cmd_drop   = cmd.drop;
   assign irq        = irq_q;

   p_irq_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !cmd.clr_irq) |=> irq);

   p_ne_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((sel == RA_CTRL) && !reg_rdata[CTL_COMMIT]) |-> !reg_rdata[CTL_NE]);

   p_drop_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == RA_CTRL) |-> !reg_rdata[CTL_DROP]);

   p_bad_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ev_bad |-> !ev_irq);
endmodule

// File: rtl/txep_dbuf_fifo.sv
module txep_dbuf_fifo #(
   parameter int DW        = 8,
   parameter int PKT_BYTES = 64,
   localparam int CW       = $clog2(PKT_BYTES + 1),
   localparam int PW       = $clog2(PKT_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_dbl_en,
   input  logic          reg_wr,
   input  logic          reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   input  logic          byte_wr,
   input  logic [DW-1:0] byte_data,
   output logic          lnk_avail,
   output logic [CW-1:0] lnk_len,
   output logic [DW-1:0] lnk_data,
   input  logic          lnk_rd,
   input  logic          lnk_done,
   output logic          irq
);
   if (PKT_BYTES < 2) begin : g_chk_depth
      $error("PKT_BYTES must be at least 2");
   end
   if (DW < 3) begin : g_chk_width
      $error("DW must hold the three control bits");
   end

   logic          cmd_commit, cmd_drop;
   logic          pkt_rdy, load_busy, ev_irq, ev_bad;
   logic          wr_en, wr_slot, rd_slot;
   logic [PW-1:0] wr_addr, rd_addr;

   txep_csr #(.DW(DW)) u_csr (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .pkt_rdy    (pkt_rdy),
      .load_busy  (load_busy),
      .ev_irq     (ev_irq),
      .ev_bad     (ev_bad),
      .cmd_commit (cmd_commit),
      .cmd_drop   (cmd_drop),
      .reg_rdata  (reg_rdata),
      .irq        (irq)
   );

   txep_slot_ctrl #(.PKT_BYTES(PKT_BYTES)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_dbl_en (cfg_dbl_en),
      .cmd_commit (cmd_commit),
      .cmd_drop   (cmd_drop),
      .byte_wr    (byte_wr),
      .lnk_rd     (lnk_rd),
      .lnk_done   (lnk_done),
      .pkt_rdy    (pkt_rdy),
      .load_busy  (load_busy),
      .ev_irq     (ev_irq),
      .ev_bad     (ev_bad),
      .wr_en      (wr_en),
      .wr_slot    (wr_slot),
      .wr_addr    (wr_addr),
      .rd_slot    (rd_slot),
      .rd_addr    (rd_addr),
      .lnk_avail  (lnk_avail),
      .lnk_len    (lnk_len)
   );

   txep_pkt_ram #(.DW(DW), .PKT_BYTES(PKT_BYTES), .NSLOT(2)) u_ram (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_slot (wr_slot),
      .wr_addr (wr_addr),
      .wr_data (byte_data),
      .rd_slot (rd_slot),
      .rd_addr (rd_addr),
      .rd_data (lnk_data)
   );
endmodule

// File: tb/sim_txep_dbuf_fifo.sv
module sim_txep_dbuf_fifo;
   localparam int DW = 8;
   localparam int CW = 7;

   localparam logic [2:0] OP_PUSH   = 3'd0;
   localparam logic [2:0] OP_COMMIT = 3'd1;
   localparam logic [2:0] OP_DROP   = 3'd2;
   localparam logic [2:0] OP_ABORT  = 3'd3;
   localparam logic [2:0] OP_DONE   = 3'd4;

   typedef struct packed {
      logic [2:0] op;
      logic [6:0] arg;
      logic [7:0] ectl;
      logic [6:0] elen;
   } vec_t;

   // double-buffer walk: R2 R4 R5 R6 R7 R8 R9 R10
   localparam vec_t VT [16] = '{
      '{OP_PUSH,   7'd3, 8'h00, 7'd0},
      '{OP_COMMIT, 7'd0, 8'h05, 7'd3},
      '{OP_PUSH,   7'd5, 8'h05, 7'd3},
      '{OP_COMMIT, 7'd0, 8'h05, 7'd3},
      '{OP_PUSH,   7'd2, 8'h05, 7'd3},
      '{OP_DROP,   7'd0, 8'h05, 7'd3},
      '{OP_DROP,   7'd0, 8'h00, 7'd0},
      '{OP_DROP,   7'd0, 8'h00, 7'd0},
      '{OP_PUSH,   7'd4, 8'h00, 7'd0},
      '{OP_COMMIT, 7'd0, 8'h05, 7'd4},
      '{OP_PUSH,   7'd6, 8'h05, 7'd4},
      '{OP_ABORT,  7'd0, 8'h05, 7'd4},
      '{OP_PUSH,   7'd2, 8'h05, 7'd4},
      '{OP_COMMIT, 7'd0, 8'h05, 7'd4},
      '{OP_DONE,   7'd0, 8'h05, 7'd2},
      '{OP_DONE,   7'd0, 8'h00, 7'd0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_dbl_en = 1'b1;
   logic          reg_wr = 1'b0;
   logic          reg_addr = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          byte_wr = 1'b0;
   logic [DW-1:0] byte_data = '0;
   logic          lnk_avail;
   logic [CW-1:0] lnk_len;
   logic [DW-1:0] lnk_data;
   logic          lnk_rd = 1'b0;
   logic          lnk_done = 1'b0;
   logic          irq;

   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   txep_dbuf_fifo u0 (
      .clk (clk), .rst_n (rst_n), .cfg_dbl_en (cfg_dbl_en),
      .reg_wr (reg_wr), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata), .byte_wr (byte_wr), .byte_data (byte_data),
      .lnk_avail (lnk_avail), .lnk_len (lnk_len), .lnk_data (lnk_data),
      .lnk_rd (lnk_rd), .lnk_done (lnk_done), .irq (irq)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic a, input logic [7:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd_reg(input logic a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic push(input int n, input logic [7:0] base, input logic [7:0] step);
      for (int i = 0; i < n; i++) begin
         byte_wr = 1'b1;
         byte_data = base + 8'(i) * step;
         @(negedge clk);
      end
      byte_wr = 1'b0;
   endtask

   task automatic done_pulse();
      lnk_done = 1'b1;
      @(negedge clk);
      lnk_done = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] rv;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd_reg(1'b0, rv); check("R1 ctrl", rv, 8'h00);
      rd_reg(1'b1, rv); check("R1 events", rv, 8'h00);
      check("R1 irq", irq, 0);
      check("R1 avail", lnk_avail, 0);
      repeat (2) @(negedge clk);

      // table walk in double-buffer mode
      for (int k = 0; k < 16; k++) begin
         case (VT[k].op)
            OP_PUSH:   push(int'(VT[k].arg), 8'h20, 8'h01);
            OP_COMMIT: wr_reg(1'b0, 8'h01);
            OP_DROP:   wr_reg(1'b0, 8'h02);
            OP_ABORT:  wr_reg(1'b0, 8'h03);
            default:   done_pulse();
         endcase
         rd_reg(1'b0, rv);
         check($sformatf("R2 R5 R6 R7 R9 R10 row %0d ctrl", k), rv, VT[k].ectl);
         check($sformatf("R4 R6 R10 row %0d len", k), lnk_len, VT[k].elen);
         check($sformatf("R2 row %0d avail", k), lnk_avail, VT[k].ectl[0]);
      end

      // R11 irq held, then cleared; R8 bad flag from table row 7
      check("R11 irq after walk", irq, 1);
      repeat (4) @(negedge clk);
      check("R11 irq still held", irq, 1);
      rd_reg(1'b1, rv); check("R11 R8 events", rv, 8'h03);
      wr_reg(1'b1, 8'h03);
      check("R11 irq cleared", irq, 0);
      rd_reg(1'b1, rv); check("R11 events cleared", rv, 8'h00);

      // R8 misused drop leaves partial bytes intact
      push(3, 8'h40, 8'h01);
      wr_reg(1'b0, 8'h02);
      rd_reg(1'b1, rv); check("R8 bad flag only", rv, 8'h02);
      check("R8 no irq", irq, 0);
      wr_reg(1'b0, 8'h01);
      check("R8 length untouched", lnk_len, 3);
      rd_reg(1'b0, rv); check("R11 drop bit reads 0", rv[1], 0);
      done_pulse();
      check("R10 irq on done", irq, 1);
      wr_reg(1'b1, 8'h03);

      // R2 byte order on the link side
      push(10, 8'h10, 8'h07);
      wr_reg(1'b0, 8'h01);
      check("R2 len 10", lnk_len, 10);
      for (int i = 0; i < 10; i++) begin
         #1;
         check($sformatf("R2 byte %0d", i), lnk_data, 8'(8'h10 + 8'(i) * 8'h07));
         lnk_rd = 1'b1;
         @(negedge clk);
         lnk_rd = 1'b0;
      end
      done_pulse();
      wr_reg(1'b1, 8'h03);

      // R3 length ceiling and ignored writes when full
      push(66, 8'h00, 8'h01);
      wr_reg(1'b0, 8'h01);
      check("R3 len saturates", lnk_len, 64);
      push(1, 8'h99, 8'h00);
      wr_reg(1'b0, 8'h01);
      push(3, 8'h55, 8'h00);
      wr_reg(1'b0, 8'h01);
      done_pulse();
      check("R3 second packet len", lnk_len, 1);
      #1; check("R3 second packet byte", lnk_data, 8'h99);
      done_pulse();
      check("R3 extra commit ignored", lnk_avail, 0);
      wr_reg(1'b1, 8'h03);

      // R12 mode change wipes buffers
      push(2, 8'h01, 8'h01);
      wr_reg(1'b0, 8'h01);
      cfg_dbl_en = 1'b0;
      repeat (2) @(negedge clk);
      check("R12 avail cleared", lnk_avail, 0);
      rd_reg(1'b0, rv); check("R12 ctrl cleared", rv, 8'h00);
      check("R12 no irq", irq, 0);

      // R4 single mode: one packet only
      push(3, 8'h30, 8'h01);
      wr_reg(1'b0, 8'h01);
      push(2, 8'h60, 8'h01);
      wr_reg(1'b0, 8'h01);
      check("R4 single len", lnk_len, 3);
      done_pulse();
      check("R4 single empty after done", lnk_avail, 0);
      wr_reg(1'b1, 8'h03);

      // R5 single mode: one drop empties
      push(2, 8'h70, 8'h01);
      wr_reg(1'b0, 8'h01);
      wr_reg(1'b0, 8'h02);
      rd_reg(1'b0, rv); check("R5 single drop empties", rv, 8'h00);
      check("R5 irq on drop", irq, 1);
      wr_reg(1'b1, 8'h03);

      // R9 partial bytes with nothing committed
      push(4, 8'h80, 8'h01);
      rd_reg(1'b0, rv); check("R9 not-empty masked", rv, 8'h00);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule